// File: doc/BRIEF.md
# Video RAM Block-Copy Engine

This engine moves data into video RAM in units of 16 bytes. Software programs a source address, a destination address and a control byte through five byte registers. Writing the control byte starts the job. The engine itself never touches data. Each cycle in which a byte should move, it raises a copy strobe together with the source and destination addresses, and the surrounding fabric performs that read and write. While bytes move, the processor is held off by a stall output.

The engine has two ways of running:

- **General mode** copies the whole programmed length in one burst, as soon as the control byte is written.
- **Blanking mode** arms the engine. It then copies one 16-byte chunk each time the video pipeline enters its blanking state (video mode 0). A running count of remaining chunks is kept in the control register.

When a run finishes, the advanced source and destination addresses are written back into the address registers. This lets a later job continue from where the last one stopped.

Top module: `vram_blk_dma`

## Requirements
- R1: The effective source address is {reg0, reg1} with bits 3:0 forced to zero. The first copy strobe of a job carries this address. Register index 0 is source high, 1 is source low, 2 is destination high, 3 is destination low and 4 is control.
- R2: A control write is dropped when the effective source lies in 0x8000 to 0x9FFF. A dropped write causes no stall, no copy, and no change to the control readback. A source of 0xA000 is accepted.
- R3: The effective destination is ({reg2, reg3} AND 0x1FF0) OR 0x8000.
- R4: A control write with bit 7 clear, made while no blanking job is armed, starts a general job at once in any video mode. The job copies (control[6:0]+1)*16 bytes. Successive copies use consecutive source and destination addresses.
- R5: With `tick` held high, a copy strobe occurs every second cycle. The first strobe comes two cycles after the starting edge. `cpuStall` rises on the starting edge and stays high until the edge after the last strobe. Copy strobes occur only while `cpuStall` is high.
- R6: When a job or chunk finishes, the four address registers read back the address following the last byte copied. After a general job, the control register reads 0xFF.
- R7: A control write with bit 7 set arms blanking mode, and the control register then reads back control[6:0] with bit 7 clear. One 16-byte chunk is copied on each entry into video mode 0 (mode 0 following a non-zero mode). If the video mode is already 0 at the write, the first chunk is copied at once.
- R8: Each finished blanking chunk decrements the control register. Once it has decremented to 0xFF, blanking mode ends and further entries into mode 0 copy nothing.
- R9: A control write with bit 7 clear while blanking mode is armed cancels the job. No copy follows. The control register then reads back its previous low 7 bits with bit 7 set.
- R10: Register writes made while `cpuStall` is high are ignored.
- R11: After reset, the address registers read 0x00, the control register reads 0xFF and `cpuStall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register write index (0 to 4) |
| regWrData | input | 8 | Register write data |
| regRdAddr | input | 3 | Register readback index |
| regRdData | output | 8 | Register readback data (combinational) |
| vidMode | input | 2 | Current video mode; 0 is the blanking state |
| tick | input | 1 | Cycle qualifier for copy pacing |
| copyStb | output | 1 | A byte is to be copied this cycle |
| copySrc | output | 16 | Source address of this copy |
| copyDst | output | 16 | Destination address of this copy |
| cpuStall | output | 1 | Processor hold-off while a job runs |

## Verification
A corrupted working address shows up on the very next copy strobe as an address that breaks the running sequence. A corrupted byte counter shows up when the stall is released: it drops too early or too late, and the strobe count disagrees with the programmed length. A wrong blanking flag or chunk count shows up on the next entry into mode 0 as a missing or extra chunk. It also shows up at once in the control readback.

// File: rtl/vdma_pkg.sv
package vdma_pkg;
  localparam int REG_SRC_HI = 0;
  localparam int REG_SRC_LO = 1;
  localparam int REG_DST_HI = 2;
  localparam int REG_DST_LO = 3;
  localparam int REG_CTRL   = 4;
  localparam int LEN_BITS   = 7;

  typedef struct packed {
    logic addrWr;      // address register write accepted
    logic loadAddr;    // load working pointers from registers
    logic step;        // one byte moved, advance pointers
    logic writeBack;   // job or chunk done, update registers
    logic ctrlStore;   // store new control value
    logic ctrlCancel;  // armed blanking job cancelled
    logic ctrlDec;     // blanking chunk finished
    logic ctrlFill;    // general job finished
  } vdma_stb_t;
endpackage

// File: rtl/vdma_ctrl.sv
module vdma_ctrl
  import vdma_pkg::*;
#(
  parameter int CHUNK_BYTES  = 16,
  parameter int CYC_PER_BYTE = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       regWrEn,
  input  logic [2:0] regAddr,
  input  logic [7:0] regWrData,
  input  logic [1:0] vidMode,
  input  logic       tick,
  input  logic       srcBad,
  input  logic [7:0] ctrlVal,
  output vdma_stb_t  stb,
  output logic       busy,
  output logic       copyStb
);
  localparam int REM_W = $clog2((2 ** LEN_BITS) * CHUNK_BYTES + 1);
  localparam int PH_W  = (CYC_PER_BYTE > 2) ? $clog2(CYC_PER_BYTE) : 1;
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_PER_BYTE - 1);

  logic            blankMode;
  logic            prevZero;
  logic [PH_W-1:0] phase;
  logic [REM_W-1:0] remain;

  logic modeZero, ctrlWr, accept, isCancel, startGen, startBlank, chunkGo, lastStep;
  logic [REM_W-1:0] genLen;

  always_comb begin
    modeZero   = (vidMode == 2'd0);
    ctrlWr     = regWrEn && (regAddr == 3'(REG_CTRL)) && !busy;
    accept     = ctrlWr && !srcBad;
    isCancel   = accept && blankMode && !regWrData[7];
    startGen   = accept && !blankMode && !regWrData[7];
    startBlank = accept && regWrData[7] && modeZero;
    chunkGo    = !busy && blankMode && modeZero && !prevZero && !ctrlWr;
    copyStb    = busy && tick && (phase == PH_LAST);
    lastStep   = copyStb && (remain == REM_W'(1));
    genLen     = (REM_W'(regWrData[LEN_BITS-1:0]) + REM_W'(1)) * REM_W'(CHUNK_BYTES);

    stb.addrWr     = regWrEn && !busy && (regAddr < 3'(REG_CTRL));
    stb.loadAddr   = accept && !isCancel;
    stb.step       = copyStb;
    stb.writeBack  = lastStep;
    stb.ctrlStore  = accept && !isCancel;
    stb.ctrlCancel = isCancel;
    stb.ctrlDec    = lastStep && blankMode;
    stb.ctrlFill   = lastStep && !blankMode;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      blankMode <= 1'b0;
      prevZero  <= 1'b1;
      phase     <= '0;
      remain    <= '0;
    end else begin
      prevZero <= modeZero;
      if (accept) blankMode <= regWrData[7];
      if (startGen || startBlank) begin
        busy   <= 1'b1;
        phase  <= '0;
        remain <= startGen ? genLen : REM_W'(CHUNK_BYTES);
      end else if (chunkGo) begin
        busy   <= 1'b1;
        phase  <= '0;
        remain <= REM_W'(CHUNK_BYTES);
      end else if (busy && tick) begin
        phase <= (phase == PH_LAST) ? '0 : phase + PH_W'(1);
        if (copyStb) remain <= remain - REM_W'(1);
        if (lastStep) begin
          busy <= 1'b0;
          if (blankMode && ctrlVal == 8'h00) blankMode <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/vdma_dpath.sv
module vdma_dpath
  import vdma_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  vdma_stb_t   stb,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWrData,
  input  logic [2:0]  regRdAddr,
  output logic [7:0]  regRdData,
  output logic        srcBad,
  output logic [7:0]  ctrlVal,
  output logic [15:0] copySrc,
  output logic [15:0] copyDst
);
  logic [7:0]  srcHi, srcLo, dstHi, dstLo, ctrlReg;
  logic [15:0] curSrc, curDst;
  logic [15:0] srcAligned, dstAligned, srcNext, dstNext;

  always_comb begin
    srcAligned = {srcHi, srcLo} & 16'hFFF0;
    dstAligned = ({dstHi, dstLo} & 16'h1FF0) | 16'h8000;
    srcBad     = (srcAligned[15:13] == 3'b100);
    srcNext    = curSrc + 16'd1;
    dstNext    = curDst + 16'd1;
    ctrlVal    = ctrlReg;
    copySrc    = curSrc;
    copyDst    = curDst;
    case (regRdAddr)
      3'(REG_SRC_HI): regRdData = srcHi;
      3'(REG_SRC_LO): regRdData = srcLo;
      3'(REG_DST_HI): regRdData = dstHi;
      3'(REG_DST_LO): regRdData = dstLo;
      3'(REG_CTRL):   regRdData = ctrlReg;
      default:        regRdData = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      srcHi   <= '0;
      srcLo   <= '0;
      dstHi   <= '0;
      dstLo   <= '0;
      ctrlReg <= 8'hFF;
      curSrc  <= '0;
      curDst  <= '0;
    end else begin
      if (stb.addrWr) begin
        case (regAddr)
          3'(REG_SRC_HI): srcHi <= regWrData;
          3'(REG_SRC_LO): srcLo <= regWrData;
          3'(REG_DST_HI): dstHi <= regWrData;
          default:        dstLo <= regWrData;
        endcase
      end
      if (stb.loadAddr) begin
        curSrc <= srcAligned;
        curDst <= dstAligned;
      end else if (stb.step) begin
        curSrc <= srcNext;
        curDst <= dstNext;
      end
      if (stb.writeBack) begin
        srcHi <= srcNext[15:8];
        srcLo <= srcNext[7:0];
        dstHi <= dstNext[15:8];
        dstLo <= dstNext[7:0];
      end
      if (stb.ctrlStore)       ctrlReg <= {1'b0, regWrData[6:0]};
      else if (stb.ctrlCancel) ctrlReg <= {1'b1, ctrlReg[6:0]};
      else if (stb.ctrlDec)    ctrlReg <= ctrlReg - 8'd1;
      else if (stb.ctrlFill)   ctrlReg <= 8'hFF;
    end
  end
endmodule

// File: rtl/vram_blk_dma.sv
module vram_blk_dma
  import vdma_pkg::*;
#(
  parameter int CHUNK_BYTES  = 16,
  parameter int CYC_PER_BYTE = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        regWrEn,
  input  logic [2:0]  regAddr,
  input  logic [7:0]  regWrData,
  input  logic [2:0]  regRdAddr,
  output logic [7:0]  regRdData,
  input  logic [1:0]  vidMode,
  input  logic        tick,
  output logic        copyStb,
  output logic [15:0] copySrc,
  output logic [15:0] copyDst,
  output logic        cpuStall
);
  vdma_stb_t stb;
  logic      srcBad;
  logic [7:0] ctrlVal;

  vdma_ctrl #(.CHUNK_BYTES(CHUNK_BYTES), .CYC_PER_BYTE(CYC_PER_BYTE)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .vidMode(vidMode), .tick(tick), .srcBad(srcBad),
    .ctrlVal(ctrlVal), .stb(stb), .busy(cpuStall), .copyStb(copyStb)
  );

  vdma_dpath u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .srcBad(srcBad), .ctrlVal(ctrlVal), .copySrc(copySrc), .copyDst(copyDst)
  );
endmodule

// File: rtl/vram_blk_dma_chk.sv
module vram_blk_dma_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        copyStb,
  input logic [15:0] copySrc,
  input logic [15:0] copyDst,
  input logic        cpuStall
);
  assert_copy_in_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    copyStb |-> cpuStall);

  assert_copy_spacing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    copyStb |=> !copyStb);

  assert_no_copy_at_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpuStall) |-> !copyStb);

  // R1 and R3: every job or chunk starts on 16-byte aligned addresses
  assert_start_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpuStall) |-> (copySrc[3:0] == 4'h0 && copyDst[3:0] == 4'h0));

  assert_end_after_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpuStall) |-> $past(copyStb));
endmodule

bind vram_blk_dma vram_blk_dma_chk u_chk (
  .clk(clk), .rst_n(rst_n), .copyStb(copyStb), .copySrc(copySrc),
  .copyDst(copyDst), .cpuStall(cpuStall)
);

// File: tb/tb_vram_blk_dma.sv
module tb_vram_blk_dma;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [7:0] regWrData = '0;
  logic [2:0] regRdAddr = '0;
  logic [7:0] regRdData;
  logic [1:0] vidMode = 2'd2;
  logic tick = 1'b1;
  logic copyStb;
  logic [15:0] copySrc, copyDst;
  logic cpuStall;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [31:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  vram_blk_dma dut (
    .clk(clk), .rst_n(rst_n), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdAddr(regRdAddr), .regRdData(regRdData),
    .vidMode(vidMode), .tick(tick), .copyStb(copyStb), .copySrc(copySrc),
    .copyDst(copyDst), .cpuStall(cpuStall)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && copyStb) begin
      if (expQ.size() == 0) begin
        chk("R8 unexpected copy", {copySrc, copyDst}, 32'h0);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        chk("R4 copy address pair", {copySrc, copyDst}, e);
      end
    end
  end

  task automatic expectCopies(logic [15:0] s, logic [15:0] d, int n);
    for (int i = 0; i < n; i++) expQ.push_back({s + 16'(i), d + 16'(i)});
  endtask

  task automatic wrReg(int idx, logic [7:0] v);
    @(posedge clk); #1;
    regWrEn = 1'b1; regAddr = 3'(idx); regWrData = v;
    @(posedge clk); #1;
    regWrEn = 1'b0;
  endtask

  task automatic rdChk(string tag, int idx, logic [7:0] exp);
    regRdAddr = 3'(idx); #1;
    chk(tag, {24'h0, regRdData}, {24'h0, exp});
  endtask

  task automatic setMode(logic [1:0] m);
    @(posedge clk); #1;
    vidMode = m;
  endtask

  task automatic waitIdle();
    repeat (3) @(negedge clk);
    for (int i = 0; i < 6000 && cpuStall; i++) @(negedge clk);
    chk("R5 stall released", {31'h0, cpuStall}, 32'h0);
    chk("R4 all expected copies seen", expQ.size(), 0);
  endtask

  task automatic setAddr(logic [7:0] sh, logic [7:0] sl, logic [7:0] dh, logic [7:0] dl);
    wrReg(0, sh); wrReg(1, sl); wrReg(2, dh); wrReg(3, dl);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++; checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    rdChk("R11 src hi", 0, 8'h00);
    rdChk("R11 dst lo", 3, 8'h00);
    rdChk("R11 ctrl", 4, 8'hFF);
    chk("R11 stall", {31'h0, cpuStall}, 32'h0);

    // R1 R3 R4 R5 R6 general job: src 0x1234->0x1230, dst 0x9567->0x9560, 32 bytes
    setAddr(8'h12, 8'h34, 8'h95, 8'h67);
    expectCopies(16'h1230, 16'h9560, 32);
    wrReg(4, 8'h01);
    chk("R5 stall right after start", {31'h0, cpuStall}, 32'h1);
    @(negedge clk);
    chk("R5 no copy in first cycle", {31'h0, copyStb}, 32'h0);
    waitIdle();
    rdChk("R6 src hi", 0, 8'h12);
    rdChk("R6 src lo", 1, 8'h50);
    rdChk("R6 dst hi", 2, 8'h95);
    rdChk("R6 dst lo", 3, 8'h80);
    rdChk("R6 ctrl after general", 4, 8'hFF);

    // R10 writes while stalled are ignored
    setAddr(8'h03, 8'h00, 8'h00, 8'h00);
    expectCopies(16'h0300, 16'h8000, 16);
    wrReg(4, 8'h00);
    wrReg(0, 8'hAA);
    wrReg(4, 8'h7F);
    waitIdle();
    rdChk("R10 src hi kept", 0, 8'h03);
    rdChk("R10 src lo", 1, 8'h10);
    rdChk("R10 ctrl", 4, 8'hFF);

    // R2 invalid sources dropped
    setAddr(8'h80, 8'h00, 8'h00, 8'h00);
    wrReg(4, 8'h00);
    chk("R2 no stall at 0x8000", {31'h0, cpuStall}, 32'h0);
    rdChk("R2 ctrl unchanged", 4, 8'hFF);
    setAddr(8'h9F, 8'hFF, 8'h00, 8'h00);
    wrReg(4, 8'h85);
    repeat (4) @(negedge clk);
    chk("R2 no stall at 0x9FF0", {31'h0, cpuStall}, 32'h0);
    rdChk("R2 ctrl unchanged blank", 4, 8'hFF);

    // R7 R8 blanking mode, three chunks
    setMode(2'd3);
    setAddr(8'h40, 8'h00, 8'h00, 8'h00);
    wrReg(4, 8'h82);
    chk("R7 armed no stall", {31'h0, cpuStall}, 32'h0);
    rdChk("R7 ctrl readback", 4, 8'h02);
    expectCopies(16'h4000, 16'h8000, 16);
    setMode(2'd0);
    waitIdle();
    rdChk("R8 ctrl after chunk 1", 4, 8'h01);
    rdChk("R6 src lo after chunk", 1, 8'h10);
    rdChk("R6 dst lo after chunk", 3, 8'h10);
    repeat (10) @(negedge clk);
    chk("R7 one chunk per entry", {31'h0, cpuStall}, 32'h0);
    setMode(2'd2);
    expectCopies(16'h4010, 16'h8010, 16);
    setMode(2'd0);
    waitIdle();
    rdChk("R8 ctrl after chunk 2", 4, 8'h00);
    setMode(2'd1);
    expectCopies(16'h4020, 16'h8020, 16);
    setMode(2'd0);
    waitIdle();
    rdChk("R8 ctrl wrapped", 4, 8'hFF);
    setMode(2'd2);
    setMode(2'd0);
    repeat (6) @(negedge clk);
    chk("R8 no chunk after end", {31'h0, cpuStall}, 32'h0);

    // R9 cancel
    setMode(2'd3);
    setAddr(8'h20, 8'h00, 8'h01, 8'h00);
    wrReg(4, 8'h83);
    rdChk("R7 ctrl armed", 4, 8'h03);
    expectCopies(16'h2000, 16'h8100, 16);
    setMode(2'd0);
    waitIdle();
    rdChk("R8 ctrl after one chunk", 4, 8'h02);
    setMode(2'd3);
    wrReg(4, 8'h05);
    chk("R9 cancel no stall", {31'h0, cpuStall}, 32'h0);
    rdChk("R9 ctrl after cancel", 4, 8'h82);
    setMode(2'd0);
    repeat (6) @(negedge clk);
    chk("R9 no chunk after cancel", {31'h0, cpuStall}, 32'h0);

    // R7 immediate chunk when already in mode 0; R2 boundary 0xA000 accepted
    setAddr(8'hA0, 8'h00, 8'h1F, 8'h00);
    expectCopies(16'hA000, 16'h9F00, 16);
    wrReg(4, 8'h81);
    chk("R2 0xA000 accepted", {31'h0, cpuStall}, 32'h1);
    waitIdle();
    rdChk("R7 ctrl after immediate", 4, 8'h00);
    setMode(2'd1);
    expectCopies(16'hA010, 16'h9F10, 16);
    setMode(2'd0);
    waitIdle();
    rdChk("R8 ctrl final", 4, 8'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule